// File: doc/BRIEF.md
# UART line coder with infrared pulse mode

This block is the serial line front end of a UART. It sits between a bit-level transmit and receive datapath and the serial pins. On the transmit side it takes one bit at a time from the shift register and drives the line for one bit cell. A bit cell is sixteen pulses of an externally supplied oversample enable. It can drive the line as plain NRZ levels. It can also use an infrared code, where a zero is a short high pulse at the start of the cell and a one leaves the line low. On the receive side it synchronises the incoming pin and offers a recovered level stream to a downstream sampler. In infrared mode, each detected pulse is widened back into a full zero cell.

Each direction has its own polarity inverter. A loopback control feeds the coded transmit line into the receive decoder in place of the pin. Hardware flow control gates the start of each character on the clear-to-send input. A setting lets characters go out regardless of that input. Either way, the synchronised clear-to-send level is reported, and each change of it can raise a one-cycle interrupt pulse. The request-to-send output follows the receiver's overrun warning.

The transmit bit interface is valid/ready. A bit is taken on a clock edge where `tx_valid` and `tx_ready` are both high. While a cell is in progress, `tx_ready` stays low. For a bit flagged as the first of a character, `tx_ready` also stays low while clear-to-send is negated, unless that gating is switched off. The source must hold `tx_bit` and `tx_sof` stable while `tx_valid` is high. The source can pause between bits by dropping `tx_valid`, and the line then idles.

Top module: `uart_line_coder`

## Requirements
- R1: In NRZ mode (`ir_mode`=0) `txd` carries the accepted bit for the whole cell and idles at 1 when no cell is active, before `tx_invert` is applied.
- R2: In infrared mode (`ir_mode`=1) a zero bit drives `txd` high for the first 3 oversample ticks of its cell and low for the rest; a one bit and the idle line are low, before `tx_invert` is applied.
- R3: `tx_invert`=1 inverts `txd` in both modes, including the idle level.
- R4: A bit is accepted only when `tx_ready` is high, and `tx_ready` is low from the accepting edge until the 16th oversample tick after it has been taken.
- R5: While the synchronised `cts_n` is high and `ignore_cts`=0, a bit with `tx_sof`=1 is not accepted; bits with `tx_sof`=0 are not gated; with `ignore_cts`=1 the start bit is accepted at once.
- R6: `cts_level` equals `cts_n` delayed by two clock stages; when `cts_irq_en`=1, every change of `cts_level` gives exactly one high cycle on `cts_irq`, and none when `cts_irq_en`=0.
- R7: `rts_n` is 1 in reset and afterwards equals `rx_overrun_warn` from the previous clock.
- R8: In NRZ mode `rx_line` equals the receive source, after `rx_invert`, delayed by two clock stages.
- R9: In infrared mode a low-to-high edge of the receive source, after `rx_invert`, drives `rx_line` to 0 for 16 oversample ticks; with no pulse `rx_line` stays 1.
- R10: `rx_invert`=1 inverts the receive source before decoding in both modes.
- R11: With `loopback`=1 the receive source is the coded `txd` and the `rxd` pin has no effect on `rx_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversample enable, 16 per bit cell |
| ir_mode | input | 1 | 0 = NRZ, 1 = infrared pulse code |
| tx_invert | input | 1 | Invert transmit line |
| rx_invert | input | 1 | Invert receive line |
| ignore_cts | input | 1 | Send without waiting for clear-to-send |
| loopback | input | 1 | Route coded transmit line to the receive decoder |
| cts_irq_en | input | 1 | Enable the clear-to-send change pulse |
| tx_valid | input | 1 | Transmit bit offered |
| tx_bit | input | 1 | Transmit bit value |
| tx_sof | input | 1 | Bit is the first of a character |
| tx_ready | output | 1 | Transmit bit can be taken |
| txd | output | 1 | Coded transmit line |
| rxd | input | 1 | Receive pin |
| rx_line | output | 1 | Recovered receive level stream |
| cts_n | input | 1 | Clear-to-send pin, active low |
| cts_level | output | 1 | Synchronised clear-to-send level |
| cts_irq | output | 1 | One-cycle pulse on each clear-to-send change |
| rx_overrun_warn | input | 1 | Receiver reports a pending overrun |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
A stuck or misaligned bit-cell phase counter shows up on `txd` within one cell. The infrared pulse would be too wide or missing at the third tick, and `tx_ready` would return early or late around the sixteenth tick. A stuck receive stretch counter leaves `rx_line` low past sixteen ticks, or returns it high too soon, within one cell of the pulse. A bad synchroniser depth shows as a shifted edge on `rx_line` and `cts_level` two clocks after the pin moves. Flow control faults appear one clock later on `rts_n`, or as a missing or doubled `cts_irq` pulse.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;
  typedef enum logic {
    LINE_NRZ = 1'b0,
    LINE_IR  = 1'b1
  } line_mode_e;
endpackage

// File: rtl/ulc_tx_coder.sv
module ulc_tx_coder
  import uart_lc_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int IR_TICKS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  line_mode_e mode,
  input  logic       tx_invert,
  input  logic       cts_ok,
  input  logic       tx_valid,
  input  logic       tx_bit,
  input  logic       tx_sof,
  output logic       tx_ready,
  output logic       txd
);
  localparam int PW = $clog2(OVERSAMPLE);

  logic          busy;
  logic [PW-1:0] phase;
  logic          cell_bit;
  logic          accept;
  logic          cell_last;
  logic          line_raw;

  // start of a character waits for clear-to-send; later bits never do
  assign tx_ready  = !busy && (!tx_sof || cts_ok);
  assign accept    = tx_valid && tx_ready;
  assign cell_last = tick16 && (phase == PW'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= '0;
      cell_bit <= 1'b1;
    end else if (accept) begin
      busy     <= 1'b1;
      phase    <= '0;
      cell_bit <= tx_bit;
    end else if (busy && tick16) begin
      phase <= phase + 1'b1;
      if (cell_last) busy <= 1'b0;
    end
  end

  always_comb begin
    if (mode == LINE_IR) line_raw = busy && !cell_bit && (phase < PW'(IR_TICKS));
    else                 line_raw = busy ? cell_bit : 1'b1;
  end

  assign txd = line_raw ^ tx_invert;

  // R4: an accepted bit opens a fresh cell at phase zero
  assert_accept_opens_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && phase == '0));

  // R4: the cell closes on the last oversample tick
  assert_cell_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cell_last && !accept) |=> !busy);

  // R2: the infrared pulse never outlasts the pulse window
  assert_ir_pulse_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LINE_IR && busy && tick16 && phase == PW'(IR_TICKS - 1) && !accept)
      |=> (mode != LINE_IR || txd == tx_invert));
endmodule

// File: rtl/ulc_rx_decoder.sv
module ulc_rx_decoder
  import uart_lc_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  line_mode_e mode,
  input  logic       rx_invert,
  input  logic       loopback,
  input  logic       rxd,
  input  logic       txd_loop,
  output logic       rx_line
);
  localparam int CW = $clog2(OVERSAMPLE + 1);

  logic                   src;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   rx_prev;
  logic                   rise;
  logic [CW-1:0]          stretch;

  assign src = loopback ? txd_loop : rxd;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b1;
        else if (s == 0) sync_q[s] <= src;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign rx_s = sync_q[SYNC_STAGES-1] ^ rx_invert;
  assign rise = rx_s && !rx_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
      stretch <= '0;
    end else begin
      rx_prev <= rx_s;
      if (rise)                          stretch <= CW'(OVERSAMPLE);
      else if (tick16 && stretch != '0)  stretch <= stretch - 1'b1;
    end
  end

  assign rx_line = (mode == LINE_IR) ? (stretch == '0) : rx_s;

  // R9: a detected pulse opens a zero cell on the next clock
  assert_ir_stretch_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LINE_IR && rise) |=> (mode != LINE_IR || !rx_line));

  // R9: the stretch only shrinks on oversample ticks
  assert_stretch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !rise) |=> (stretch == $past(stretch)));
endmodule

// File: rtl/ulc_flow_ctrl.sv
module ulc_flow_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic cts_irq_en,
  input  logic rx_overrun_warn,
  output logic cts_level,
  output logic cts_irq,
  output logic rts_n
);
  logic [SYNC_STAGES-1:0] cts_q;
  logic                   cts_prev;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cts_q[s] <= 1'b1;
        else if (s == 0) cts_q[s] <= cts_n;
        else cts_q[s] <= cts_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign cts_level = cts_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_prev <= 1'b1;
      cts_irq  <= 1'b0;
      rts_n    <= 1'b1;
    end else begin
      cts_prev <= cts_level;
      cts_irq  <= cts_irq_en && (cts_level ^ cts_prev);
      rts_n    <= rx_overrun_warn;
    end
  end

  // R7: a pending overrun negates request-to-send one clock later
  assert_rts_negate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_warn |=> rts_n);

  // R7: with no overrun warning request-to-send is asserted
  assert_rts_assert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_overrun_warn |=> !rts_n);

  // R6: the change pulse only appears when it was enabled
  assert_irq_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cts_irq |-> $past(cts_irq_en));

  // R6: the change pulse lasts one cycle while the level holds
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_irq && $stable(cts_level)) |=> !cts_irq);
endmodule

// File: rtl/uart_line_coder.sv
module uart_line_coder
  import uart_lc_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int IR_TICKS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ir_mode,
  input  logic tx_invert,
  input  logic rx_invert,
  input  logic ignore_cts,
  input  logic loopback,
  input  logic cts_irq_en,
  input  logic tx_valid,
  input  logic tx_bit,
  input  logic tx_sof,
  output logic tx_ready,
  output logic txd,
  input  logic rxd,
  output logic rx_line,
  input  logic cts_n,
  output logic cts_level,
  output logic cts_irq,
  input  logic rx_overrun_warn,
  output logic rts_n
);
  line_mode_e mode;
  logic       cts_ok;

  assign mode   = ir_mode ? LINE_IR : LINE_NRZ;
  assign cts_ok = ignore_cts || !cts_level;

  ulc_tx_coder #(
    .OVERSAMPLE(OVERSAMPLE),
    .IR_TICKS  (IR_TICKS)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .mode     (mode),
    .tx_invert(tx_invert),
    .cts_ok   (cts_ok),
    .tx_valid (tx_valid),
    .tx_bit   (tx_bit),
    .tx_sof   (tx_sof),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

  ulc_rx_decoder #(
    .OVERSAMPLE (OVERSAMPLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .mode     (mode),
    .rx_invert(rx_invert),
    .loopback (loopback),
    .rxd      (rxd),
    .txd_loop (txd),
    .rx_line  (rx_line)
  );

  ulc_flow_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_flow (
    .clk            (clk),
    .rst_n          (rst_n),
    .cts_n          (cts_n),
    .cts_irq_en     (cts_irq_en),
    .rx_overrun_warn(rx_overrun_warn),
    .cts_level      (cts_level),
    .cts_irq        (cts_irq),
    .rts_n          (rts_n)
  );

  // R5: a character start is held while clear-to-send is negated
  assert_cts_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sof && cts_level && !ignore_cts) |-> !tx_ready);
endmodule

// File: tb/uart_line_coder_tb_top.sv
`timescale 1ns/1ps
module uart_line_coder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic ir_mode = 1'b0, tx_invert = 1'b0, rx_invert = 1'b0;
  logic ignore_cts = 1'b0, loopback = 1'b0, cts_irq_en = 1'b0;
  logic tx_valid = 1'b0, tx_bit = 1'b1, tx_sof = 1'b0;
  logic rxd = 1'b1, cts_n = 1'b0, rx_overrun_warn = 1'b0;
  logic tx_ready, txd, rx_line, cts_level, cts_irq, rts_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_line_coder dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .ir_mode(ir_mode),
    .tx_invert(tx_invert), .rx_invert(rx_invert), .ignore_cts(ignore_cts),
    .loopback(loopback), .cts_irq_en(cts_irq_en), .tx_valid(tx_valid),
    .tx_bit(tx_bit), .tx_sof(tx_sof), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_line(rx_line), .cts_n(cts_n), .cts_level(cts_level),
    .cts_irq(cts_irq), .rx_overrun_warn(rx_overrun_warn), .rts_n(rts_n)
  );

  // oversample enable: one clock in four, driven away from the active edge
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick16 = (div == 3);
      div = (div + 1) % 4;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (tick16) k++;
    end
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic sof);
    @(negedge clk);
    tx_bit = b; tx_sof = sof; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  function automatic int count_irq_dummy(input int x);
    return x;
  endfunction

  // {ir_mode, tx_invert, bit, txd at tick 1, txd at tick 8, txd idle}
  localparam logic [5:0] VEC [8] = '{
    6'b000_001, 6'b001_111, 6'b010_110, 6'b011_000,
    6'b100_100, 6'b101_000, 6'b110_011, 6'b111_111
  };

  initial begin
    int irqs;
    // reset state
    repeat (3) @(negedge clk);
    check("R7 rts in reset", rts_n, 1'b1);
    check("R1 txd idle in reset", txd, 1'b1);
    check("R9 rx_line idle in reset", rx_line, 1'b1);
    check("R6 irq in reset", cts_irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 ready after reset", tx_ready, 1'b1);
    check("R7 rts after reset", rts_n, 1'b0);

    // table of transmit cells: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ir_mode = VEC[i][5]; tx_invert = VEC[i][4];
      send_bit(VEC[i][3], 1'b1);
      check("R4 busy after accept", tx_ready, 1'b0);
      wait_ticks(1);
      check(VEC[i][5] ? "R2 tick1 (R3)" : "R1 tick1 (R3)", txd, VEC[i][2]);
      wait_ticks(7);
      check(VEC[i][5] ? "R2 tick8 (R3)" : "R1 tick8 (R3)", txd, VEC[i][1]);
      wait_ticks(7);
      check("R4 still busy at tick15", tx_ready, 1'b0);
      wait_ticks(1);
      check("R4 ready after tick16", tx_ready, 1'b1);
      check(VEC[i][5] ? "R2 idle (R3)" : "R1 idle (R3)", txd, VEC[i][0]);
    end
    ir_mode = 1'b0; tx_invert = 1'b0;

    // R5 clear-to-send gating, R6 level
    @(negedge clk);
    cts_n = 1'b1;
    @(negedge clk);
    check("R6 cts_level one stage", cts_level, 1'b0);
    @(negedge clk);
    check("R6 cts_level two stages", cts_level, 1'b1);
    tx_bit = 1'b0; tx_sof = 1'b1; tx_valid = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 start held", tx_ready, 1'b0);
    check("R5 line untouched", txd, 1'b1);
    tx_valid = 1'b0; tx_sof = 1'b0;
    @(negedge clk);
    check("R5 mid-character not gated", tx_ready, 1'b1);
    tx_sof = 1'b1; ignore_cts = 1'b1;
    @(negedge clk);
    check("R5 ignore_cts releases start", tx_ready, 1'b1);
    ignore_cts = 1'b0; tx_sof = 1'b0;

    // R6 change interrupt
    cts_irq_en = 1'b1;
    @(negedge clk);
    cts_n = 1'b0;
    irqs = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); irqs += cts_irq; end
    check("R6 one pulse per change", irqs == 1, 1'b1);
    cts_irq_en = 1'b0;
    cts_n = 1'b1;
    irqs = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); irqs += cts_irq; end
    check("R6 no pulse when disabled", irqs == 0, 1'b1);
    cts_n = 1'b0;

    // R7 request-to-send
    rx_overrun_warn = 1'b1;
    @(negedge clk);
    check("R7 rts negated", rts_n, 1'b1);
    rx_overrun_warn = 1'b0;
    @(negedge clk);
    check("R7 rts asserted", rts_n, 1'b0);

    // R8 NRZ receive latency, R10 inversion
    repeat (3) @(negedge clk);
    rxd = 1'b0;
    @(negedge clk);
    check("R8 not yet through sync", rx_line, 1'b1);
    @(negedge clk);
    check("R8 through two stages", rx_line, 1'b0);
    rx_invert = 1'b1;
    @(negedge clk);
    check("R10 inverted NRZ", rx_line, 1'b1);
    rx_invert = 1'b0;

    // R9 infrared receive
    ir_mode = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 no pulse reads one", rx_line, 1'b1);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    rxd = 1'b0;
    wait_ticks(12);
    check("R9 stretched zero", rx_line, 1'b0);
    wait_ticks(6);
    check("R9 stretch ends", rx_line, 1'b1);
    // R10 infrared with inverted pin: idle pin high, pulse low
    rx_invert = 1'b1; rxd = 1'b1;
    repeat (4) @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    wait_ticks(6);
    check("R10 inverted infrared pulse", rx_line, 1'b0);
    wait_ticks(14);
    rx_invert = 1'b0;

    // R11 loopback, pin held opposite
    ir_mode = 1'b0; loopback = 1'b1; rxd = 1'b1;
    repeat (4) @(negedge clk);
    send_bit(1'b0, 1'b0);
    wait_ticks(8);
    check("R11 NRZ loopback zero", rx_line, 1'b0);
    rxd = 1'b0;
    wait_ticks(10);
    check("R11 pin ignored", rx_line, 1'b1);
    ir_mode = 1'b1;
    repeat (4) @(negedge clk);
    send_bit(1'b0, 1'b0);
    wait_ticks(8);
    check("R11 infrared loopback zero", rx_line, 1'b0);
    wait_ticks(24);
    check("R11 infrared loopback idle", rx_line, 1'b1);

    irqs = count_irq_dummy(0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + irqs);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule